// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM Core

This block is a synthesizable synchronous static memory. Each word is 36 bits: four 9-bit lanes, each made of one data byte and one parity bit. It is built for back-to-back traffic. A read or a write can start on any clock edge, and there are no idle cycles between them. Read data flows straight out of the array after the edge that registers the address. Write data arrives one enabled edge later. Because of that delay, a read can follow a write, and a write can follow a read, with no turnaround cycle on the bus.

One registered address can serve four consecutive accesses. A two-bit burst count steps the low address bits, either in linear order or in interleaved order, and the access always stays inside its four-word block. An active-low clock enable freezes the whole block on any edge. An asynchronous output enable gates the read drive. The depth is set by the parameter `ADDR_W`. The default is 10 bits, which keeps elaboration small. A full-size build uses 17 bits (128K words).

Access states: `ST_IDLE` (deselected, outputs off), `ST_READ` and `ST_WRITE`. The state moves only on an enabled edge (`cen_n` low), as follows:
- When `ld_n` is low with `sel_n` low, the block goes to `ST_READ` if `we_n` is high, or to `ST_WRITE` if `we_n` is low. This happens from any state.
- When `ld_n` is low with `sel_n` high, the block goes to `ST_IDLE` from any state.
- When `ld_n` is high, the block keeps its current state and the burst continues.

Top module: `fb_sram_core`

## Requirements
- R1: The array holds 2**ADDR_W words of 36 bits. A read returns the last value written to that word.
- R2: A read is flow-through. After the enabled edge that registers a read access, `dq_oe` is 1 and `dq_out` shows the word, with no further register stage.
- R3: An enabled edge with `ld_n`=0 and `sel_n`=0 loads `addr` and resets the burst count to 0. `we_n`=1 starts a read and `we_n`=0 starts a write.
- R4: With `mode`=0 at the load, each following enabled edge with `ld_n`=1 adds 1 to the burst count. The low two address bits are then the loaded low bits plus the count, modulo 4, and the upper bits stay the same. For example, base 6 gives 6, 7, 4, 5.
- R5: With `mode`=1 at the load, the low two address bits are the loaded low bits XOR the count. For example, base 9 gives 9, 8, 11, 10. Changes on `mode` during a burst have no effect.
- R6: A continuing access keeps the type (read or write) set at its load. `we_n` is ignored while `ld_n`=1.
- R7: The data for a write access is taken from `dq_in` at the next enabled edge after the edge that registered the access. The `bw_n` value registered with the access is active low. Bit i writes `dq_in[8i+7:8i]` and parity bit `dq_in[32+i]`, and lanes whose bit is high keep their old contents.
- R8: A read may directly follow a write, and a write may directly follow a read, with no idle cycle. A read of the word written just before it returns the new data.
- R9: An edge with `cen_n`=1 is ignored. The access state, the burst address, the pending write and the outputs all hold.
- R10: An enabled edge with `ld_n`=0 and `sel_n`=1 deselects the block. `dq_oe` is 0 after that edge, and continuing edges write nothing until the next load.
- R11: `oe_n`=1 forces `dq_oe` low and `dq_out` to 0 without disturbing the access or the burst.
- R12: After reset the block is deselected and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen_n | input | 1 | Clock enable, active low |
| sel_n | input | 1 | Chip select, active low, sampled at a load |
| we_n | input | 1 | Write select at a load, active low |
| ld_n | input | 1 | Load a new address when low, continue the burst when high |
| mode | input | 1 | Burst order at a load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| bw_n | input | 4 | Lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 36 | Write data |
| dq_out | output | 36 | Read data, 0 when not driving |
| dq_oe | output | 1 | High while `dq_out` should drive the bus |

## Verification
Read results are due in the same cycle as the edge that registers the read. The bench therefore drives on the falling edge and samples 1 ns after the following rising edge. Write data is applied in the cycle after its address, and it appears at the earliest one edge later, when a read of that word is registered. A reference model is updated at every enabled edge, using the values that were present at that edge. The model and every literal expected word are compared at that sampling point, so a frozen edge or a deselect is judged on the next sample.

// File: rtl/fb_sram_pkg.sv
package fb_sram_pkg;
    localparam int BYTE_W    = 8;
    localparam int LANES     = 4;
    localparam int LANE_W    = BYTE_W + 1;
    localparam int WORD_W    = LANES * LANE_W;
    localparam int PAR_BASE  = BYTE_W * LANES;
    localparam int BURST_W   = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_state_e;
endpackage

// File: rtl/fb_access_fsm.sv
module fb_access_fsm
    import fb_sram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cen_n,
    input  logic       sel_n,
    input  logic       we_n,
    input  logic       ld_n,
    output acc_state_e state_q,
    output logic       rd_live,
    output logic       wr_live
);
    acc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!ld_n && !sel_n) state_d = we_n ? ST_READ : ST_WRITE;
                else                 state_d = ST_IDLE;
            end
            ST_READ, ST_WRITE: begin
                if (!ld_n) begin
                    if (sel_n) state_d = ST_IDLE;
                    else       state_d = we_n ? ST_READ : ST_WRITE;
                end else begin
                    state_d = state_q;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= ST_IDLE;
        else if (!cen_n) state_q <= state_d;
    end

    always_comb begin
        rd_live = (state_q == ST_READ);
        wr_live = (state_q == ST_WRITE);
    end

    // R9: a suspended edge leaves the access state alone
    a_r9_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(state_q));

    // R6: a continuing edge keeps the access type
    a_r6_type_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && ld_n) |=> (state_q == $past(state_q)));

    // R10: a deselecting load ends in the idle state
    a_r10_desel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !ld_n && sel_n) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/fb_burst_addr.sv
module fb_burst_addr
    import fb_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              mode_in,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic               ilv_q;
    logic [BURST_W-1:0] low_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b0;
        end else if (step_en) begin
            if (load) begin
                base_q <= addr_in;
                cnt_q  <= '0;
                ilv_q  <= mode_in;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        if (ilv_q) low_bits = base_q[BURST_W-1:0] ^ cnt_q;
        else       low_bits = base_q[BURST_W-1:0] + cnt_q;
        cur_addr = {base_q[ADDR_W-1:BURST_W], low_bits};
    end

    // R3: a load presents the external address on the next access
    a_r3_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && load) |=> (cur_addr == $past(addr_in)));

    // R4: a continuing step stays inside its four-word block
    a_r4_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load) |=>
        (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])));

    // R9: a suspended edge keeps the burst address
    a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(cur_addr));

    initial begin
        a_r4_width: assert (HI_W >= 1);
    end
endmodule

// File: rtl/fb_lane_array.sv
module fb_lane_array
    import fb_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  lane_en,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_l [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && lane_en[g])
                mem_l[addr] <= {wdata[PAR_BASE+g], wdata[g*BYTE_W +: BYTE_W]};
        end

        assign rdata[g*BYTE_W +: BYTE_W] = mem_l[addr][BYTE_W-1:0];
        assign rdata[PAR_BASE+g]         = mem_l[addr][BYTE_W];
    end
endmodule

// File: rtl/fb_sram_core.sv
module fb_sram_core
    import fb_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              sel_n,
    input  logic              we_n,
    input  logic              ld_n,
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        bw_n,
    input  logic              oe_n,
    input  logic [35:0]       dq_in,
    output logic [35:0]       dq_out,
    output logic              dq_oe
);
    acc_state_e        state_q;
    logic              rd_live;
    logic              wr_live;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  bw_q;
    logic [WORD_W-1:0] rd_word;
    logic              wr_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bw_q <= '1;
        else if (!cen_n) bw_q <= bw_n;
    end

    fb_access_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cen_n   (cen_n),
        .sel_n   (sel_n),
        .we_n    (we_n),
        .ld_n    (ld_n),
        .state_q (state_q),
        .rd_live (rd_live),
        .wr_live (wr_live)
    );

    fb_burst_addr #(.ADDR_W(ADDR_W)) i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (!cen_n),
        .load     (!ld_n),
        .addr_in  (addr),
        .mode_in  (mode),
        .cur_addr (cur_addr)
    );

    assign wr_fire = !cen_n && wr_live;

    fb_lane_array #(.ADDR_W(ADDR_W)) i_array (
        .clk     (clk),
        .wr_en   (wr_fire),
        .addr    (cur_addr),
        .wdata   (dq_in),
        .lane_en (~bw_q),
        .rdata   (rd_word)
    );

    always_comb begin
        dq_oe  = rd_live && !oe_n;
        dq_out = dq_oe ? rd_word : '0;
    end

    // R10: outputs released after a deselecting load
    a_r10_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !ld_n && sel_n) |=> !dq_oe);

    // R2: a registered read drives in the very next cycle
    a_r2_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !ld_n && !sel_n && we_n) |=> (dq_oe || oe_n));

    // R7: a write lands only on an edge that follows a write registration
    a_r7_write_late: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !ld_n && !sel_n && !we_n) |=> wr_live);
endmodule

// File: tb/test_fb_sram_core.sv
module test_fb_sram_core;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cen_n = 1'b0, sel_n = 1'b1, we_n = 1'b1, ld_n = 1'b1;
    logic          mode = 1'b0, oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [3:0]    bw_n = 4'hF;
    logic [35:0]   dq_in = '0;
    logic [35:0]   dq_out;
    logic          dq_oe;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [35:0]   ref_mem [DEPTH];
    int            m_st = 0;          // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_ilv = 1'b0;
    logic [3:0]    m_bw = 4'hF;

    always #2 clk = ~clk;

    fb_sram_core #(.ADDR_W(AW)) i_fb_sram_core (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sel_n(sel_n), .we_n(we_n),
        .ld_n(ld_n), .mode(mode), .addr(addr), .bw_n(bw_n), .oe_n(oe_n),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [35:0] pat(input int a);
        logic [31:0] lo = 32'(a) * 32'h9E37_79B1 + 32'h1357_2468;
        return {4'(a * 3 + 1), lo};
    endfunction

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] low = m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], low};
    endfunction

    function automatic logic [35:0] pend_data();
        return (m_st == 2) ? pat(int'(m_addr()) + 7) : {4'h0, $urandom()};
    endfunction

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic c_n, input logic s_n, input logic w_n, input logic l_n,
                        input logic md, input logic o_n, input logic [3:0] bw,
                        input logic [AW-1:0] a, input logic [35:0] d, input string tag);
        @(negedge clk);
        cen_n = c_n; sel_n = s_n; we_n = w_n; ld_n = l_n;
        mode = md; oe_n = o_n; bw_n = bw; addr = a; dq_in = d;
        @(posedge clk);
        if (!c_n) begin
            if (m_st == 2) begin
                for (int i = 0; i < 4; i++) begin
                    if (!m_bw[i]) begin
                        ref_mem[m_addr()][i*8 +: 8] = d[i*8 +: 8];
                        ref_mem[m_addr()][32+i]     = d[32+i];
                    end
                end
            end
            if (!l_n) begin
                m_st = s_n ? 0 : (w_n ? 1 : 2);
                m_base = a; m_cnt = '0; m_ilv = md;
            end else begin
                m_cnt = m_cnt + 2'd1;
            end
            m_bw = bw;
        end
        #1;
        chk({tag, " oe"}, {35'd0, dq_oe}, {35'd0, (m_st == 1) && !o_n});
        if ((m_st == 1) && !o_n) chk({tag, " data"}, dq_out, ref_mem[m_addr()]);
        else                     chk({tag, " quiet"}, dq_out, 36'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog actual=expired expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [35:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset oe", {35'd0, dq_oe}, 36'd0);
        chk("R12 reset data", dq_out, 36'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // fill every word with known data in linear write bursts
        for (int b = 0; b < DEPTH; b += 4) begin
            for (int k = 0; k < 4; k++) begin
                v = (m_st == 2) ? pat(int'(m_addr())) : 36'd0;
                step(0, 0, 0, (k == 0) ? 1'b0 : 1'b1, 0, 0, 4'h0, AW'(b), v, "R7 fill");
            end
        end
        step(0, 0, 1, 0, 0, 0, 4'hF, AW'(0), pat(int'(m_addr())), "R1 flush");

        // linear burst from 6: 6,7,4,5
        step(0, 0, 1, 0, 0, 0, 4'hF, AW'(6), 36'd0, "R3 load");
        chk("R3 R2 first word", dq_out, pat(6));
        step(0, 0, 1, 1, 0, 0, 4'hF, AW'(0), 36'd0, "R4");
        chk("R4 second", dq_out, pat(7));
        step(0, 0, 1, 1, 0, 0, 4'hF, AW'(0), 36'd0, "R4");
        chk("R4 third wraps", dq_out, pat(4));
        step(0, 0, 1, 1, 0, 0, 4'hF, AW'(0), 36'd0, "R4");
        chk("R4 fourth", dq_out, pat(5));

        // interleaved burst from 9: 9,8,11,10, mode pin dropped mid-burst
        step(0, 0, 1, 0, 1, 0, 4'hF, AW'(9), 36'd0, "R5");
        chk("R5 first", dq_out, pat(9));
        step(0, 0, 1, 1, 0, 0, 4'hF, AW'(0), 36'd0, "R5");
        chk("R5 second", dq_out, pat(8));
        step(0, 0, 1, 1, 0, 0, 4'hF, AW'(0), 36'd0, "R5");
        chk("R5 third", dq_out, pat(11));
        step(0, 0, 1, 1, 1, 0, 4'hF, AW'(0), 36'd0, "R5");
        chk("R5 fourth", dq_out, pat(10));

        // lane mask: lanes 0 and 2 written
        step(0, 0, 0, 0, 0, 0, 4'b1010, AW'(20), 36'd0, "R7");
        step(0, 0, 1, 0, 0, 0, 4'hF, AW'(20), 36'hF_FFFF_FFFF, "R7");
        chk("R7 lanes", dq_out, (pat(20) & ~36'h5_00FF_00FF) | 36'h5_00FF_00FF);

        // write burst ignores we_n while continuing
        step(0, 0, 0, 0, 0, 0, 4'h0, AW'(70), 36'd0, "R6");
        step(0, 0, 1, 1, 0, 0, 4'h0, AW'(0), 36'h1_1111_1111, "R6");
        chk("R6 still write", {35'd0, dq_oe}, 36'd0);
        step(0, 0, 1, 0, 0, 0, 4'hF, AW'(71), 36'h2_2222_2222, "R6");
        chk("R6 R8 second word", dq_out, 36'h2_2222_2222);
        step(0, 0, 1, 0, 0, 0, 4'hF, AW'(70), 36'd0, "R6");
        chk("R6 first word", dq_out, 36'h1_1111_1111);

        // back-to-back write/read/write/read
        step(0, 0, 0, 0, 0, 0, 4'h0, AW'(40), 36'd0, "R8");
        step(0, 0, 1, 0, 0, 0, 4'hF, AW'(40), 36'h3_3333_3333, "R8");
        chk("R8 read after write", dq_out, 36'h3_3333_3333);
        step(0, 0, 0, 0, 0, 0, 4'h0, AW'(41), 36'd0, "R8");
        step(0, 0, 1, 0, 0, 0, 4'hF, AW'(41), 36'h4_4444_4444, "R8");
        chk("R8 write after read", dq_out, 36'h4_4444_4444);

        // clock suspension
        step(0, 0, 1, 0, 0, 0, 4'hF, AW'(50), 36'd0, "R9");
        step(1, 0, 0, 0, 0, 0, 4'h0, AW'(51), 36'd0, "R9");
        chk("R9 held read", dq_out, pat(50));
        step(0, 0, 0, 0, 0, 0, 4'h0, AW'(60), 36'd0, "R9");
        step(1, 0, 1, 0, 0, 0, 4'hF, AW'(61), 36'h6_6666_6666, "R9");
        step(0, 0, 1, 0, 0, 0, 4'hF, AW'(60), 36'h5_5555_5555, "R9");
        chk("R9 pending write kept", dq_out, 36'h5_5555_5555);

        // output enable
        step(0, 0, 1, 0, 0, 1, 4'hF, AW'(100), 36'd0, "R11");
        chk("R11 gated", {35'd0, dq_oe}, 36'd0);
        step(0, 0, 1, 1, 0, 0, 4'hF, AW'(0), 36'd0, "R11");
        chk("R11 burst went on", dq_out, pat(101));

        // deselect
        step(0, 1, 0, 0, 0, 0, 4'h0, AW'(100), 36'd0, "R10");
        chk("R10 off", {35'd0, dq_oe}, 36'd0);
        step(0, 0, 0, 1, 0, 0, 4'h0, AW'(0), 36'h7_7777_7777, "R10");
        step(0, 0, 0, 1, 0, 0, 4'h0, AW'(0), 36'h7_7777_7777, "R10");
        step(0, 0, 1, 0, 0, 0, 4'hF, AW'(100), 36'h7_7777_7777, "R10");
        chk("R10 no write", dq_out, pat(100));

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            step(($urandom_range(7) == 0), ($urandom_range(5) == 0), $urandom_range(1) == 1,
                 ($urandom_range(2) != 0), $urandom_range(1) == 1, ($urandom_range(9) == 0),
                 4'($urandom_range(15)), AW'($urandom_range(DEPTH - 1)), pend_data(), "R1 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule